// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block chooses the two ALU source operands for the first execute stage (EX1) of an in-order, eight-stage pipeline: F1, F2, ID, EX1, EX2, M1, M2, RW. Each operand can come from one of four places. The first is the value read from the register file in ID. The other three are results held in the EX2/M1, M1/M2 and M2/RW pipeline registers. The block compares the EX1 instruction's source register numbers against the destination register numbers of the four older instructions in EX2, M1, M2 and RW. For each operand it drives a 2-bit select and the selected operand. The mux that uses the select is part of the block.

The ALU takes two cycles, so a result exists only once EX2 has finished. Load data exists only once M2 has finished. When the youngest matching producer cannot yet supply its value, no forward happens and a per-operand "not forwardable" flag is raised. A separate stall unit uses that flag. That unit, the register file and the memory-stage forwarding lie outside this block. The register file writes in the first half of RW and reads in the second half of ID, so producers further ahead need no forwarding.

The block is purely combinational. Its control half computes the match and priority decisions and hands a small struct of selects to the datapath half, which holds the two operand muxes.

Top module: `fwd_ex_unit`

## Requirements
- R1: With no qualifying match, an operand's select is 2'b00 and the operand equals the register-file value.
- R2: A source register number of zero never matches any producer, even one whose destination is zero and write enable is set. The select stays 2'b00 and the flag stays low.
- R3: When an operand's use qualifier is low, that operand never matches.
- R4: When the youngest match is a non-load in M1, the select is 2'b01 and the operand equals the EX2/M1 value.
- R5: When the youngest match is a non-load in M2, the select is 2'b10 and the operand equals the M1/M2 value.
- R6: When the youngest match is in RW, load or not, the select is 2'b11 and the operand equals the M2/RW value.
- R7: When the youngest match is the instruction in EX2, the select is 2'b00 and the not-forwardable flag is high.
- R8: When the youngest match is a load in M1 or M2, the select is 2'b00 and the not-forwardable flag is high.
- R9: When several producers match, only the youngest one decides the outcome. Youth runs EX2, M1, M2, RW, youngest first.
- R10: A producer whose write enable is low never matches, whatever its load flag.
- R11: The two operands are resolved independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcRegA | input | REG_AW | First source register number of the EX1 instruction |
| srcRegB | input | REG_AW | Second source register number of the EX1 instruction |
| useA | input | 1 | First source field is used |
| useB | input | 1 | Second source field is used |
| ex2Rd | input | REG_AW | Destination register of the EX2 instruction |
| ex2We | input | 1 | EX2 instruction writes a register |
| ex2Ld | input | 1 | EX2 instruction is a load |
| m1Rd | input | REG_AW | Destination register of the M1 instruction |
| m1We | input | 1 | M1 instruction writes a register |
| m1Ld | input | 1 | M1 instruction is a load |
| m2Rd | input | REG_AW | Destination register of the M2 instruction |
| m2We | input | 1 | M2 instruction writes a register |
| m2Ld | input | 1 | M2 instruction is a load |
| rwRd | input | REG_AW | Destination register of the RW instruction |
| rwWe | input | 1 | RW instruction writes a register |
| rwLd | input | 1 | RW instruction is a load |
| rfDataA | input | XLEN | Register-file value for the first operand |
| rfDataB | input | XLEN | Register-file value for the second operand |
| exm1Data | input | XLEN | ALU result in the EX2/M1 register |
| m1m2Data | input | XLEN | ALU result in the M1/M2 register |
| m2rwData | input | XLEN | ALU result or load data in the M2/RW register |
| opA | output | XLEN | First ALU operand |
| opB | output | XLEN | Second ALU operand |
| selA | output | 2 | First operand select: 00 register file, 01 EX2/M1, 10 M1/M2, 11 M2/RW |
| selB | output | 2 | Second operand select, same encoding |
| noFwdA | output | 1 | First operand's youngest match cannot be forwarded |
| noFwdB | output | 1 | Second operand's youngest match cannot be forwarded |

## Verification
The bench builds the block with REG_AW=2 and XLEN=8. With only four register numbers, every producer's destination-and-kind combination can be crossed with every source number. The kinds are no write, ALU write and load write. That covers all 12^4 producer configurations for each source value, including every priority conflict and every zero-register case. Each of the five data inputs carries a distinct constant, so a wrong mux leg shows up directly in the operand value.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF   = 2'b00,
    SEL_EXM1 = 2'b01,
    SEL_M1M2 = 2'b10,
    SEL_M2RW = 2'b11
  } fwdSel_e;

  typedef struct packed {
    fwdSel_e selA;
    fwdSel_e selB;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] srcRegA,
  input  logic [REG_AW-1:0] srcRegB,
  input  logic              useA,
  input  logic              useB,
  input  logic [REG_AW-1:0] ex2Rd,
  input  logic              ex2We,
  input  logic              ex2Ld,
  input  logic [REG_AW-1:0] m1Rd,
  input  logic              m1We,
  input  logic              m1Ld,
  input  logic [REG_AW-1:0] m2Rd,
  input  logic              m2We,
  input  logic              m2Ld,
  input  logic [REG_AW-1:0] rwRd,
  input  logic              rwWe,
  output fwdStrobe_t        strobe,
  output logic [1:0]        noFwd
);
  localparam int NUM_OPS = 2;

  logic [1:0] selArr [NUM_OPS];

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    logic [REG_AW-1:0] rsNum;
    logic              rsUsed;
    logic              hitEx2, hitM1, hitM2, hitRw;
    logic [1:0]        selVal;
    logic              blkVal;

    assign rsNum  = (op == 0) ? srcRegA : srcRegB;
    assign rsUsed = ((op == 0) ? useA : useB) && (rsNum != '0);
    assign hitEx2 = rsUsed && ex2We && (ex2Rd == rsNum);
    assign hitM1  = rsUsed && m1We  && (m1Rd  == rsNum);
    assign hitM2  = rsUsed && m2We  && (m2Rd  == rsNum);
    assign hitRw  = rsUsed && rwWe  && (rwRd  == rsNum);

    always_comb begin
      selVal = SEL_RF;
      blkVal = 1'b0;
      if (hitEx2) begin
        blkVal = 1'b1;
      end else if (hitM1) begin
        if (m1Ld) blkVal = 1'b1;
        else      selVal = SEL_EXM1;
      end else if (hitM2) begin
        if (m2Ld) blkVal = 1'b1;
        else      selVal = SEL_M1M2;
      end else if (hitRw) begin
        selVal = SEL_M2RW;
      end
    end

    assign selArr[op] = selVal;
    assign noFwd[op]  = blkVal;
  end

  assign strobe.selA = fwdSel_e'(selArr[0]);
  assign strobe.selB = fwdSel_e'(selArr[1]);

  always_comb begin
    AST_BLOCK_HOLDS_RF: assert (!noFwd[0] || strobe.selA == SEL_RF) else $error("blocked operand A selected a forward"); // R7
    AST_ZERO_NEVER_FWD: assert (srcRegA != '0 || (strobe.selA == SEL_RF && !noFwd[0])) else $error("x0 matched on A"); // R2
    AST_UNUSED_QUIET: assert (useB || (strobe.selB == SEL_RF && !noFwd[1])) else $error("unused B matched"); // R3
    AST_LOAD_NOT_EARLY: assert (!((strobe.selA == SEL_EXM1 && m1Ld) || (strobe.selA == SEL_M1M2 && m2Ld))) else $error("load forwarded early"); // R8
    AST_NO_EX2_FWD: assert (!(useA && ex2We && ex2Rd == srcRegA && srcRegA != '0) || noFwd[0]) else $error("EX2 match not flagged"); // R7
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fwdStrobe_t      strobe,
  input  logic [XLEN-1:0] rfDataA,
  input  logic [XLEN-1:0] rfDataB,
  input  logic [XLEN-1:0] exm1Data,
  input  logic [XLEN-1:0] m1m2Data,
  input  logic [XLEN-1:0] m2rwData,
  output logic [XLEN-1:0] opA,
  output logic [XLEN-1:0] opB
);
  localparam int NUM_OPS = 2;

  logic [XLEN-1:0] opArr [NUM_OPS];

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_mux
    fwdSel_e         sel;
    logic [XLEN-1:0] rfVal;
    logic [XLEN-1:0] outVal;

    assign sel   = (op == 0) ? strobe.selA : strobe.selB;
    assign rfVal = (op == 0) ? rfDataA : rfDataB;

    always_comb begin
      unique case (sel)
        SEL_EXM1: outVal = exm1Data;
        SEL_M1M2: outVal = m1m2Data;
        SEL_M2RW: outVal = m2rwData;
        default:  outVal = rfVal;
      endcase
    end

    assign opArr[op] = outVal;
  end

  assign opA = opArr[0];
  assign opB = opArr[1];
endmodule

// File: rtl/fwd_ex_unit.sv
module fwd_ex_unit
  import fwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] srcRegA,
  input  logic [REG_AW-1:0] srcRegB,
  input  logic              useA,
  input  logic              useB,
  input  logic [REG_AW-1:0] ex2Rd,
  input  logic              ex2We,
  input  logic              ex2Ld,
  input  logic [REG_AW-1:0] m1Rd,
  input  logic              m1We,
  input  logic              m1Ld,
  input  logic [REG_AW-1:0] m2Rd,
  input  logic              m2We,
  input  logic              m2Ld,
  input  logic [REG_AW-1:0] rwRd,
  input  logic              rwWe,
  input  logic              rwLd,
  input  logic [XLEN-1:0]   rfDataA,
  input  logic [XLEN-1:0]   rfDataB,
  input  logic [XLEN-1:0]   exm1Data,
  input  logic [XLEN-1:0]   m1m2Data,
  input  logic [XLEN-1:0]   m2rwData,
  output logic [XLEN-1:0]   opA,
  output logic [XLEN-1:0]   opB,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic              noFwdA,
  output logic              noFwdB
);
  fwdStrobe_t strobe;
  logic [1:0] noFwd;
  logic       unusedLd;

  // The M2/RW register carries ALU results and load data alike, so the RW kind is irrelevant here.
  assign unusedLd = rwLd ^ ex2Ld;

  fwd_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .srcRegA(srcRegA), .srcRegB(srcRegB), .useA(useA), .useB(useB),
    .ex2Rd(ex2Rd), .ex2We(ex2We), .ex2Ld(unusedLd & 1'b0),
    .m1Rd(m1Rd), .m1We(m1We), .m1Ld(m1Ld),
    .m2Rd(m2Rd), .m2We(m2We), .m2Ld(m2Ld),
    .rwRd(rwRd), .rwWe(rwWe),
    .strobe(strobe), .noFwd(noFwd)
  );

  fwd_datapath #(.XLEN(XLEN)) u_dp (
    .strobe(strobe), .rfDataA(rfDataA), .rfDataB(rfDataB),
    .exm1Data(exm1Data), .m1m2Data(m1m2Data), .m2rwData(m2rwData),
    .opA(opA), .opB(opB)
  );

  assign selA   = strobe.selA;
  assign selB   = strobe.selB;
  assign noFwdA = noFwd[0];
  assign noFwdB = noFwd[1];
endmodule

// File: tb/fwd_ex_unit_tb.sv
module fwd_ex_unit_tb;
  localparam int XLEN   = 8;
  localparam int REG_AW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [REG_AW-1:0] srcRegA, srcRegB, ex2Rd, m1Rd, m2Rd, rwRd;
  logic useA, useB, ex2We, ex2Ld, m1We, m1Ld, m2We, m2Ld, rwWe, rwLd;
  logic [XLEN-1:0] rfDataA, rfDataB, exm1Data, m1m2Data, m2rwData, opA, opB;
  logic [1:0] selA, selB;
  logic noFwdA, noFwdB;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  fwd_ex_unit #(.XLEN(XLEN), .REG_AW(REG_AW)) u_dut (.*);

  logic [REG_AW-1:0] pRd [4];
  logic              pWe [4];
  logic              pLd [4];

  // Walk the producers from oldest (RW) to youngest (EX2): the last hit wins.
  task automatic expect_op(input logic [REG_AW-1:0] rs, input logic used,
                           output logic [1:0] eSel, output logic eBlk, output string tag);
    eSel = 2'b00; eBlk = 1'b0;
    tag = (rs == 0) ? "R2" : (!used ? "R3" : "R1");
    for (int k = 3; k >= 0; k--) begin
      if (used && rs != 0 && pWe[k] && pRd[k] == rs) begin
        if (tag != "R1") tag = "R9";
        case (k)
          0: begin eSel = 2'b00; eBlk = 1'b1; if (tag == "R1") tag = "R7"; end
          1, 2: begin
            if (pLd[k]) begin eSel = 2'b00; eBlk = 1'b1; if (tag == "R1") tag = "R8"; end
            else begin eSel = 2'(k); eBlk = 1'b0; if (tag == "R1") tag = (k == 1) ? "R4" : "R5"; end
          end
          default: begin eSel = 2'b11; eBlk = 1'b0; tag = "R6"; end
        endcase
        if (tag == "R6" && k != 3) tag = "R9";
      end else if (!pWe[k] && pRd[k] == rs && used && rs != 0 && tag == "R1") begin
        tag = "R10";
      end
    end
  endtask

  function automatic logic [XLEN-1:0] data_for(input logic [1:0] s, input logic [XLEN-1:0] rf);
    case (s)
      2'b01: return exm1Data;
      2'b10: return m1m2Data;
      2'b11: return m2rwData;
      default: return rf;
    endcase
  endfunction

  task automatic check(input string tag, input string name,
                       input logic [1:0] gSel, input logic gBlk, input logic [XLEN-1:0] gOp,
                       input logic [1:0] eSel, input logic eBlk, input logic [XLEN-1:0] eOp);
    checks++;
    if (gSel !== eSel || gBlk !== eBlk || gOp !== eOp) begin
      errors++;
      $display("FAIL %s %s: sel=%b blk=%b op=%h expected sel=%b blk=%b op=%h",
               tag, name, gSel, gBlk, gOp, eSel, eBlk, eOp);
    end
  endtask

  task automatic apply_stages();
    ex2Rd = pRd[0]; ex2We = pWe[0]; ex2Ld = pLd[0];
    m1Rd  = pRd[1]; m1We  = pWe[1]; m1Ld  = pLd[1];
    m2Rd  = pRd[2]; m2We  = pWe[2]; m2Ld  = pLd[2];
    rwRd  = pRd[3]; rwWe  = pWe[3]; rwLd  = pLd[3];
  endtask

  task automatic check_both();
    logic [1:0] eSel; logic eBlk; string tag;
    #1;
    expect_op(srcRegA, useA, eSel, eBlk, tag);
    check(tag, "opA", selA, noFwdA, opA, eSel, eBlk, data_for(eSel, rfDataA));
    expect_op(srcRegB, useB, eSel, eBlk, tag);
    check(tag, "opB", selB, noFwdB, opB, eSel, eBlk, data_for(eSel, rfDataB));
  endtask

  initial begin
    rfDataA = 8'h11; rfDataB = 8'h22; exm1Data = 8'h33; m1m2Data = 8'h44; m2rwData = 8'h55;
    for (int k = 0; k < 4; k++) begin pRd[k] = '0; pWe[k] = 1'b0; pLd[k] = 1'b0; end
    apply_stages();
    srcRegA = 2'd1; srcRegB = 2'd2; useA = 1'b1; useB = 1'b1;
    @(negedge clk);
    check("R1", "idle A", selA, noFwdA, opA, 2'b00, 1'b0, 8'h11);
    check("R1", "idle B", selB, noFwdB, opB, 2'b00, 1'b0, 8'h22);

    // R11: A hits M1, B hits RW in the same cycle.
    pRd[1] = 2'd1; pWe[1] = 1'b1; pRd[3] = 2'd2; pWe[3] = 1'b1; pLd[3] = 1'b1;
    apply_stages();
    @(negedge clk);
    check("R11", "split A", selA, noFwdA, opA, 2'b01, 1'b0, 8'h33);
    check("R11", "split B", selB, noFwdB, opB, 2'b11, 1'b0, 8'h55);

    // Full sweep: each stage takes rd 0..3 and kind {no write (load flag set), alu, load}.
    for (int cfg = 0; cfg < 20736; cfg++) begin
      int c = cfg;
      for (int k = 0; k < 4; k++) begin
        pRd[k] = 2'(c % 4);
        pWe[k] = ((c / 4) % 3) != 0;
        pLd[k] = ((c / 4) % 3) != 1;
        c = c / 12;
      end
      apply_stages();
      for (int r = 0; r < 4; r++) begin
        srcRegA = 2'(r);
        srcRegB = 2'(3 - r);
        useA = ((cfg + r) % 5) != 0;
        useB = ((cfg + r) % 7) != 0;
        check_both();
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule